// File: doc/BRIEF.md
# SCSI Command Legality Sequencer

This block sits between a CPU command register and a SCSI phase engine. The CPU writes an 8-bit command code. The block keeps track of the bus connection: free, linked as initiator, or linked as target. It also knows whether an engine operation is still running. From these two facts it decides, in the same cycle as the write, whether the command runs, is quietly dropped, or is refused with an error flag. The command already in progress is never disturbed by a refused command.

An accepted engine command produces a one-cycle start pulse and an operation code, and raises busy until the engine reports completion. Only the engine's connect and disconnect reports move the link state. Assert-attention does not start the engine. It sets the attention output directly, and only while the link is in the initiator role. Two interrupt status registers record errors, completions, a good-status completion and phase-check failures. The CPU clears a bit by writing a one to it, normally by writing back the value it read. The interrupt output is the OR of all status bits.

Link states and their transitions: LINK_FREE goes to LINK_INIT or LINK_TGT on a connect report, with the role taken from the role input. LINK_INIT and LINK_TGT go to LINK_FREE on a disconnect report. A disconnect report takes priority over a connect report in the same cycle. A connect report in a linked state re-selects the role. Execution states: EXEC_IDLE goes to EXEC_RUN when a command is accepted. EXEC_RUN goes to EXEC_IDLE on engine done.

Top module: `cmd_legality_seq`

## Requirements
- R1: After reset the link is free (link_state=0), busy=0, atn_out=0, eng_start=0, eng_op=0, stat1=0, stat2=0 and irq=0.
- R2: link_state is 0 for free, 1 for initiator and 2 for target. It changes only on engine reports and takes its new value one cycle after the report. eng_disc gives 0 and takes priority over eng_conn. eng_conn gives 2 when eng_conn_tgt=1 and 1 otherwise.
- R3: Code 07h with link_state=1 sets atn_out in the next cycle, even while busy. In the free or target states the code changes no output and flags no error. atn_out is 0 whenever link_state is not 1.
- R4: Code 0Bh (select then command) is accepted in every link state when idle. One cycle later eng_start=1 for one cycle, eng_op=1 and busy=1.
- R5: Any engine command (0Bh, 0Eh, 15h, 1Dh) written while busy sets stat2 bit 0 (command error). busy and eng_op stay unchanged and no start pulse is produced.
- R6: Code 0Eh (wait for reselection) runs with eng_op=2 only when free. When linked it sets stat2 bit 0.
- R7: Code 15h (data in) runs with eng_op=3 in the initiator or target state. When free it sets stat2 bit 0.
- R8: Code 1Dh (send status) runs with eng_op=4 only in the target state, and otherwise sets stat2 bit 0. Its completion sets stat1 bit 2 (good).
- R9: Any other code sets stat2 bit 0.
- R10: A phase check (phase_chk=1) with phase_is_cmd=0 sets stat1 bit 0 (illegal phase). With phase_is_cmd=1 it sets nothing.
- R11: eng_done while busy sets stat1 bit 1, clears busy and returns eng_op to 0, one cycle later. eng_done while idle has no effect.
- R12: stat_wr clears the bits of stat1 (stat_sel=0) or stat2 (stat_sel=1) that are one in stat_wdata. A set in the same cycle wins. irq is 1 exactly when any status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| eng_done | input | 1 | Engine reports that the running operation finished |
| eng_conn | input | 1 | Engine reports that the bus is connected |
| eng_conn_tgt | input | 1 | Role for eng_conn: 1 target, 0 initiator |
| eng_disc | input | 1 | Engine reports that the bus is disconnected |
| phase_chk | input | 1 | Engine performs a command-phase check |
| phase_is_cmd | input | 1 | Observed phase is the command phase |
| stat_wr | input | 1 | Status clear strobe |
| stat_sel | input | 1 | 0 selects stat1, 1 selects stat2 |
| stat_wdata | input | 8 | Bits to clear |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 3 | Running operation code, 0 when idle |
| busy | output | 1 | An engine operation is running |
| atn_out | output | 1 | Attention request |
| link_state | output | 2 | Connection state |
| stat1 | output | 8 | Status 1: bit0 illegal phase, bit1 done, bit2 good |
| stat2 | output | 8 | Status 2: bit0 command error |
| irq | output | 1 | Interrupt request |

## Verification
A wrong link state would appear on link_state one cycle after the report that caused it. It would then give the wrong verdict on the next command written: a stray start pulse, a missing error bit, or attention raised outside the initiator role. A wrong execution state would either let a second start pulse through while busy, or flag an error with busy low. Both show one cycle after the offending write. The bench's model predicts every output on every cycle, so such a fault is reported in the first cycle in which it becomes visible.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
    localparam int CODE_W = 8;
    localparam int STAT_W = 8;
    localparam int OP_W   = 3;

    localparam logic [CODE_W-1:0] CODE_ATN     = 8'h07;
    localparam logic [CODE_W-1:0] CODE_SELECT  = 8'h0B;
    localparam logic [CODE_W-1:0] CODE_RESEL   = 8'h0E;
    localparam logic [CODE_W-1:0] CODE_DATA_IN = 8'h15;
    localparam logic [CODE_W-1:0] CODE_STATUS  = 8'h1D;

    localparam int S1_ILL_BIT  = 0;
    localparam int S1_DONE_BIT = 1;
    localparam int S1_GOOD_BIT = 2;
    localparam int S2_ERR_BIT  = 0;

    typedef enum logic [1:0] {
        LINK_FREE = 2'd0,
        LINK_INIT = 2'd1,
        LINK_TGT  = 2'd2
    } link_t;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 3'd0,
        OP_SELECT  = 3'd1,
        OP_RESEL   = 3'd2,
        OP_DATA_IN = 3'd3,
        OP_STATUS  = 3'd4
    } op_t;

    typedef enum logic [1:0] {
        V_IGNORE = 2'd0,
        V_RUN    = 2'd1,
        V_ERROR  = 2'd2,
        V_ATN    = 2'd3
    } verdict_t;
endpackage

// File: rtl/seq_cmd_judge.sv
module seq_cmd_judge
    import scsi_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  link_t             link,
    input  logic              busy,
    output verdict_t          verdict,
    output op_t               op
);
    always_comb begin
        verdict = V_ERROR;
        op      = OP_NONE;
        case (code)
            CODE_ATN: begin
                verdict = (link == LINK_INIT) ? V_ATN : V_IGNORE;
            end
            CODE_SELECT: begin
                op      = OP_SELECT;
                verdict = busy ? V_ERROR : V_RUN;
            end
            CODE_RESEL: begin
                op      = OP_RESEL;
                verdict = (busy || link != LINK_FREE) ? V_ERROR : V_RUN;
            end
            CODE_DATA_IN: begin
                op      = OP_DATA_IN;
                verdict = (busy || link == LINK_FREE) ? V_ERROR : V_RUN;
            end
            CODE_STATUS: begin
                op      = OP_STATUS;
                verdict = (busy || link != LINK_TGT) ? V_ERROR : V_RUN;
            end
            default: begin
                verdict = V_ERROR;
                op      = OP_NONE;
            end
        endcase
    end
endmodule

// File: rtl/seq_link_fsm.sv
module seq_link_fsm
    import scsi_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  conn,
    input  logic  conn_tgt,
    input  logic  disc,
    input  logic  atn_req,
    output link_t link,
    output logic  atn
);
    link_t link_nx;
    logic  atn_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link <= LINK_FREE;
            atn  <= 1'b0;
        end else begin
            link <= link_nx;
            atn  <= atn_nx;
        end
    end

    always_comb begin
        link_nx = link;
        unique case (link)
            LINK_FREE: begin
                if (!disc && conn) link_nx = conn_tgt ? LINK_TGT : LINK_INIT;
            end
            LINK_INIT, LINK_TGT: begin
                if (disc)      link_nx = LINK_FREE;
                else if (conn) link_nx = conn_tgt ? LINK_TGT : LINK_INIT;
            end
            default: link_nx = LINK_FREE;
        endcase
        atn_nx = (link_nx == LINK_INIT) && (atn || atn_req);
    end
endmodule

// File: rtl/seq_exec_fsm.sv
module seq_exec_fsm
    import scsi_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  op_t  run_op,
    input  logic done_in,
    output logic busy,
    output logic start,
    output op_t  op,
    output logic done_evt,
    output logic good_evt
);
    typedef enum logic {EXEC_IDLE = 1'b0, EXEC_RUN = 1'b1} exec_t;
    exec_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= EXEC_IDLE;
            op    <= OP_NONE;
            start <= 1'b0;
        end else begin
            state <= state_nx;
            start <= (state == EXEC_IDLE) && run_req;
            if (state == EXEC_IDLE && run_req) op <= run_op;
            else if (state == EXEC_RUN && done_in) op <= OP_NONE;
        end
    end

    always_comb begin
        state_nx = state;
        done_evt = 1'b0;
        good_evt = 1'b0;
        unique case (state)
            EXEC_IDLE: if (run_req) state_nx = EXEC_RUN;
            EXEC_RUN: begin
                if (done_in) begin
                    state_nx = EXEC_IDLE;
                    done_evt = 1'b1;
                    good_evt = (op == OP_STATUS);
                end
            end
            default: state_nx = EXEC_IDLE;
        endcase
    end

    assign busy = (state == EXEC_RUN);
endmodule

// File: rtl/seq_status_regs.sv
module seq_status_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set1,
    input  logic [W-1:0] set2,
    input  logic         clr_wr,
    input  logic         clr_sel,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] s1,
    output logic [W-1:0] s2
);
    logic [W-1:0] clr1, clr2;

    assign clr1 = (clr_wr && !clr_sel) ? clr_mask : '0;
    assign clr2 = (clr_wr &&  clr_sel) ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= (s1 & ~clr1) | set1;
            s2 <= (s2 & ~clr2) | set2;
        end
    end
endmodule

// File: rtl/cmd_legality_seq.sv
module cmd_legality_seq
    import scsi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              eng_done,
    input  logic              eng_conn,
    input  logic              eng_conn_tgt,
    input  logic              eng_disc,
    input  logic              phase_chk,
    input  logic              phase_is_cmd,
    input  logic              stat_wr,
    input  logic              stat_sel,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              eng_start,
    output logic [OP_W-1:0]   eng_op,
    output logic              busy,
    output logic              atn_out,
    output logic [1:0]        link_state,
    output logic [STAT_W-1:0] stat1,
    output logic [STAT_W-1:0] stat2,
    output logic              irq
);
    link_t        link;
    verdict_t     verdict;
    op_t          dec_op, run_op;
    logic         busy_i, done_evt, good_evt;
    logic [STAT_W-1:0] set1, set2;

    seq_cmd_judge u_judge (
        .code(cmd_code), .link(link), .busy(busy_i),
        .verdict(verdict), .op(dec_op)
    );

    seq_link_fsm u_link (
        .clk(clk), .rst_n(rst_n), .conn(eng_conn), .conn_tgt(eng_conn_tgt),
        .disc(eng_disc), .atn_req(cmd_wr && verdict == V_ATN),
        .link(link), .atn(atn_out)
    );

    seq_exec_fsm u_exec (
        .clk(clk), .rst_n(rst_n), .run_req(cmd_wr && verdict == V_RUN),
        .run_op(dec_op), .done_in(eng_done), .busy(busy_i),
        .start(eng_start), .op(run_op), .done_evt(done_evt), .good_evt(good_evt)
    );

    always_comb begin
        set1 = '0;
        set2 = '0;
        set1[S1_ILL_BIT]  = phase_chk && !phase_is_cmd;
        set1[S1_DONE_BIT] = done_evt;
        set1[S1_GOOD_BIT] = good_evt;
        set2[S2_ERR_BIT]  = cmd_wr && verdict == V_ERROR;
    end

    seq_status_regs #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set1(set1), .set2(set2),
        .clr_wr(stat_wr), .clr_sel(stat_sel), .clr_mask(stat_wdata),
        .s1(stat1), .s2(stat2)
    );

    assign busy       = busy_i;
    assign eng_op     = run_op;
    assign link_state = link;
    assign irq        = (|stat1) || (|stat2);
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [7:0] cmd_code,
    input logic       eng_done,
    input logic       eng_disc,
    input logic       phase_chk,
    input logic       phase_is_cmd,
    input logic       eng_start,
    input logic       busy,
    input logic       atn_out,
    input logic [1:0] link_state,
    input logic [7:0] stat1,
    input logic [7:0] stat2
);
    // R5
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !eng_done && cmd_code == 8'h0B) |=> (stat2[0] && busy && !eng_start));
    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (busy && !$past(busy)));
    // R3
    atn_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        atn_out |-> (link_state == 2'd1));
    // R10
    ill_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_chk && !phase_is_cmd) |=> stat1[0]);
    // R6
    resel_linked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 8'h0E && link_state != 2'd0) |=> (stat2[0] && !eng_start));
    // R2
    disc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_disc |=> (link_state == 2'd0));
endmodule

bind cmd_legality_seq seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .eng_done(eng_done), .eng_disc(eng_disc), .phase_chk(phase_chk),
    .phase_is_cmd(phase_is_cmd), .eng_start(eng_start), .busy(busy),
    .atn_out(atn_out), .link_state(link_state), .stat1(stat1), .stat2(stat2)
);

// File: tb/tb_cmd_legality_seq.sv
module tb_cmd_legality_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 0, eng_done = 0, eng_conn = 0, eng_conn_tgt = 0, eng_disc = 0;
    logic       phase_chk = 0, phase_is_cmd = 0, stat_wr = 0, stat_sel = 0;
    logic [7:0] cmd_code = 0, stat_wdata = 0;
    logic       eng_start, busy, atn_out, irq;
    logic [2:0] eng_op;
    logic [1:0] link_state;
    logic [7:0] stat1, stat2;

    always #10 clk = ~clk;

    cmd_legality_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .eng_done(eng_done), .eng_conn(eng_conn), .eng_conn_tgt(eng_conn_tgt),
        .eng_disc(eng_disc), .phase_chk(phase_chk), .phase_is_cmd(phase_is_cmd),
        .stat_wr(stat_wr), .stat_sel(stat_sel), .stat_wdata(stat_wdata),
        .eng_start(eng_start), .eng_op(eng_op), .busy(busy), .atn_out(atn_out),
        .link_state(link_state), .stat1(stat1), .stat2(stat2), .irq(irq)
    );

    // behavioural reference model
    int m_link, m_op, m_s1, m_s2;
    bit m_busy, m_atn, m_start;
    int total = 0, bad = 0;
    string cur_req = "R1";
    bit finished = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_link = 0; m_op = 0; m_s1 = 0; m_s2 = 0;
            m_busy = 0; m_atn = 0; m_start = 0;
        end else begin
            bit err, go, was_busy;
            int nop, old_link;
            err = 0; go = 0; nop = 0;
            was_busy = m_busy; old_link = m_link;
            m_start = 0;
            if (stat_wr) begin
                if (stat_sel) m_s2 = m_s2 & ~int'(stat_wdata);
                else          m_s1 = m_s1 & ~int'(stat_wdata);
            end
            if (phase_chk && !phase_is_cmd) m_s1 = m_s1 | 1;
            if (eng_done && was_busy) begin
                m_s1 = m_s1 | 2;
                if (m_op == 4) m_s1 = m_s1 | 4;
                m_busy = 0; m_op = 0;
            end
            if (cmd_wr) begin
                case (cmd_code)
                    8'h07: ;
                    8'h0B: if (was_busy) err = 1; else begin go = 1; nop = 1; end
                    8'h0E: if (was_busy || old_link != 0) err = 1; else begin go = 1; nop = 2; end
                    8'h15: if (was_busy || old_link == 0) err = 1; else begin go = 1; nop = 3; end
                    8'h1D: if (was_busy || old_link != 2) err = 1; else begin go = 1; nop = 4; end
                    default: err = 1;
                endcase
            end
            if (err) m_s2 = m_s2 | 1;
            if (go) begin m_busy = 1; m_op = nop; m_start = 1; end
            if (eng_disc) m_link = 0;
            else if (eng_conn) m_link = eng_conn_tgt ? 2 : 1;
            if (m_link != 1) m_atn = 0;
            else if (cmd_wr && cmd_code == 8'h07 && old_link == 1) m_atn = 1;
        end
    end

    task automatic check(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("link_state", int'(link_state), m_link);
            check("busy", int'(busy), int'(m_busy));
            check("eng_op", int'(eng_op), m_op);
            check("eng_start", int'(eng_start), int'(m_start));
            check("atn_out", int'(atn_out), int'(m_atn));
            check("stat1", int'(stat1), m_s1);
            check("stat2", int'(stat2), m_s2);
            check("irq", int'(irq), int'(m_s1 != 0 || m_s2 != 0));
        end
    end

    task automatic drive(bit wr, logic [7:0] code, bit done, bit conn, bit tgt, bit disc,
                         bit pchk, bit pcmd, bit swr, bit ssel, logic [7:0] sdat);
        @(negedge clk);
        cmd_wr = wr; cmd_code = code; eng_done = done; eng_conn = conn;
        eng_conn_tgt = tgt; eng_disc = disc; phase_chk = pchk; phase_is_cmd = pcmd;
        stat_wr = swr; stat_sel = ssel; stat_wdata = sdat;
        @(negedge clk);
        cmd_wr = 0; eng_done = 0; eng_conn = 0; eng_disc = 0; phase_chk = 0; stat_wr = 0;
    endtask

    task automatic cmd(logic [7:0] c);  drive(1, c, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic done();               drive(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic conn(bit t);          drive(0, 0, 0, 1, t, 0, 0, 0, 0, 0, 0); endtask
    task automatic disc();               drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
    task automatic clr(bit s, logic [7:0] d); drive(0, 0, 0, 0, 0, 0, 0, 0, 1, s, d); endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("reset link", int'(link_state), 0);
        check("reset stat", int'(stat1) + int'(stat2) + int'(irq) + int'(busy), 0);
        cur_req = "R9"; cmd(8'h42); check("undef code err", int'(stat2[0]), 1);
        cur_req = "R12"; clr(1, 8'h01); check("w1c stat2", int'(stat2), 0);
        cur_req = "R7"; cmd(8'h15); check("data-in free err", int'(stat2[0]), 1);
        clr(1, 8'hFF);
        cur_req = "R3"; cmd(8'h07); check("atn in free", int'(atn_out), 0);
        check("atn in free no err", int'(stat2), 0);
        cur_req = "R6"; cmd(8'h0E); check("resel free op", int'(eng_op), 2);
        cur_req = "R5"; cmd(8'h0B); check("busy err", int'(stat2[0]), 1);
        check("busy op kept", int'(eng_op), 2);
        cur_req = "R11"; done(); check("done bit", int'(stat1[1]), 1);
        done(); clr(0, 8'hFF); clr(1, 8'hFF);
        cur_req = "R2"; conn(0); check("link init", int'(link_state), 1);
        cur_req = "R3"; cmd(8'h07); check("atn in init", int'(atn_out), 1);
        cur_req = "R4"; cmd(8'h0B); check("select op", int'(eng_op), 1);
        cur_req = "R3"; cmd(8'h07);
        cur_req = "R7"; cmd(8'h15); done();
        cmd(8'h15); check("data-in init op", int'(eng_op), 3); done();
        cur_req = "R6"; cmd(8'h0E); check("resel linked err", int'(stat2[0]), 1);
        cur_req = "R8"; clr(1, 8'h01); cmd(8'h1D); check("status init err", int'(stat2[0]), 1);
        cur_req = "R2"; conn(1); check("link tgt", int'(link_state), 2);
        cur_req = "R3"; check("atn drops", int'(atn_out), 0);
        cmd(8'h07); check("atn in tgt", int'(atn_out), 0);
        cur_req = "R8"; clr(0, 8'hFF); clr(1, 8'hFF);
        cmd(8'h1D); check("status op", int'(eng_op), 4);
        done(); check("good bit", int'(stat1[2]), 1);
        cur_req = "R10"; clr(0, 8'hFF);
        drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0); check("phase ok", int'(stat1), 0);
        drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0); check("phase bad", int'(stat1[0]), 1);
        cur_req = "R12"; drive(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 8'h01);
        check("set wins clear", int'(stat1[0]), 1);
        cur_req = "R11"; clr(0, 8'hFF); done(); check("idle done ignored", int'(stat1), 0);
        cur_req = "R4"; cmd(8'h0B); check("select in tgt", int'(busy), 1); done();
        cur_req = "R2"; drive(0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); check("disc wins", int'(link_state), 0);
        cur_req = "R4"; cmd(8'h0B); check("select in free", int'(eng_op), 1); done();
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [7:0] c;
            k = $urandom_range(0, 6);
            case (k)
                0: c = 8'h07; 1: c = 8'h0B; 2: c = 8'h0E; 3: c = 8'h15;
                4: c = 8'h1D; 5: c = 8'h3A; default: c = 8'h0B;
            endcase
            drive(($urandom_range(0, 2) == 0), c, ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 9) == 0), $urandom_range(0, 1), ($urandom_range(0, 14) == 0),
                  ($urandom_range(0, 7) == 0), $urandom_range(0, 1),
                  ($urandom_range(0, 5) == 0), $urandom_range(0, 1), 8'($urandom));
        end
        finished = 1;
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finished = 1;
        summary();
    end
endmodule